// File: doc/BRIEF.md
# Buffer Descriptor List Walker

This block sequences the address side of a DMA engine whose work comes from a list of buffer descriptors in host memory. Once started from a programmed list base, it fetches each descriptor one word at a time through a single-outstanding memory read port. It refuses descriptors the host still owns, and it decodes up to two data buffers per descriptor. It hands those buffers to a data mover one at a time and waits for the mover's done pulse on each.

Each descriptor is four 32-bit words at consecutive addresses: status (ownership in bit 31), control with sizes and layout flags, first buffer address, and second buffer address or link. When the last usable buffer of a descriptor is done, the walker writes the status word back with ownership cleared. It then computes the next descriptor address. The list may be a plain ring with fixed stride, an end-of-ring wrap back to the base, or a chain that follows a link pointer held in the fourth word.

Top module: `desc_walker`

## Requirements
- R1: While reset is high and in the cycle after it, `rd_en`, `wr_en`, `buf_valid` and `stalled` are all low.
- R2: A descriptor at address A is fetched as four reads at A, A+4, A+8, A+12, in that order, each read address word aligned.
- R3: If status bit 31 of a fetched descriptor is 0 (host owned), no buffer is presented and `stalled` goes high. The walker re-reads that status word every few cycles and resumes when bit 31 reads 1.
- R4: The first buffer size is control bits 10:0 and the second is bits 21:11. A presented length is the size rounded down to a multiple of four, and a presented length is never zero.
- R5: If the first buffer's rounded size is zero, the walker presents the second buffer directly (word 3 address).
- R6: If the second buffer's rounded size is zero, the descriptor ends after the first buffer (or at once if both are zero) and the walker moves on.
- R7: With control bits 25 and 24 both clear, the next descriptor address is the current address plus 16.
- R8: With control bit 24 (chain) set and bit 25 clear, word 3 is the next descriptor address and is never presented as a buffer.
- R9: With control bit 25 (end of ring) set, the next descriptor address is the list base, whatever bit 24 holds, and word 3 is treated as a data buffer.
- R10: A presented buffer keeps `buf_valid`, `buf_addr` and `buf_len` steady until `buf_done`. Buffers appear one at a time, first buffer before second.
- R11: After a descriptor's last buffer is done, or at once if it has none, one write to the descriptor address carries the status word with bit 31 cleared and all other bits unchanged. This write happens before the next descriptor is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse in idle: begin walking at `base_addr` |
| base_addr | input | AW | List base, captured on `start` |
| rd_en | output | 1 | Read request, one cycle |
| rd_addr | output | AW | Read word address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| wr_en | output | 1 | Status write-back strobe, one cycle |
| wr_addr | output | AW | Status write-back address |
| wr_data | output | 32 | Status word with ownership cleared |
| buf_valid | output | 1 | A buffer is presented |
| buf_addr | output | AW | Presented buffer address |
| buf_len | output | 11 | Presented buffer length in bytes |
| buf_done | input | 1 | Data mover finished the presented buffer |
| stalled | output | 1 | Waiting on a host-owned descriptor |

## Verification
The list mixes stride-16 descriptors with a chained descriptor whose link jumps forward and an end-of-ring descriptor that also has the chain bit set. Together these separate the three next-address rules, and they show that end of ring decides both the next address and whether word 3 is data. Size patterns cover two usable buffers, first-buffer-empty, second-buffer-empty, both-empty, and sizes that are not multiples of four. Each of these tells apart a distinct buffer-selection path or the rounding rule. The walker's own ownership write-backs make the wrap land on a host-owned descriptor, so the stall and re-poll are exercised. Re-arming that descriptor then shows recovery in place.

// File: rtl/dw_pkg.sv
package dw_pkg;
  localparam int DW         = 32;
  localparam int OWN_BIT    = 31;
  localparam int EOR_BIT    = 25;
  localparam int CHAIN_BIT  = 24;
  localparam int SZ_W       = 11;
  localparam int SZ1_LSB    = 0;
  localparam int SZ2_LSB    = 11;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = DESC_WORDS * (DW / 8);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_STALL,
    ST_PICK,
    ST_BUF,
    ST_CLEAR
  } walk_st_e;
endpackage

// File: rtl/dw_desc_regs.sv
module dw_desc_regs #(
  parameter int NW = 4,
  parameter int W  = 32,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [IW-1:0]        idx,
  input  logic [W-1:0]         din,
  output logic [NW-1:0][W-1:0] words
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)
        r <= '0;
      else if (load && idx == IW'(g))
        r <= din;
    end
    assign words[g] = r;
  end
endmodule

// File: rtl/dw_buf_select.sv
module dw_buf_select
  import dw_pkg::*;
#(
  parameter int SZW = SZ_W
) (
  input  logic [DW-1:0]  ctrl_word,
  output logic [SZW-1:0] len1,
  output logic [SZW-1:0] len2,
  output logic           use1,
  output logic           use2,
  output logic           eor,
  output logic           chain
);
  logic [SZW-1:0] raw1, raw2;

  always_comb begin
    raw1  = ctrl_word[SZ1_LSB +: SZW];
    raw2  = ctrl_word[SZ2_LSB +: SZW];
    len1  = {raw1[SZW-1:2], 2'b00};
    len2  = {raw2[SZW-1:2], 2'b00};
    eor   = ctrl_word[EOR_BIT];
    chain = ctrl_word[CHAIN_BIT];
    use1  = |len1;
    // word 3 is a data buffer unless it is a live link (end of ring wins)
    use2  = (|len2) && (!chain || eor);
  end
endmodule

// File: rtl/dw_next_addr.sv
module dw_next_addr
  import dw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] link,
  input  logic          eor,
  input  logic          chain,
  output logic [AW-1:0] nxt
);
  always_comb begin
    if (eor)
      nxt = base;
    else if (chain)
      nxt = link[AW-1:0];
    else
      nxt = cur + AW'(DESC_BYTES);
  end
endmodule

// File: rtl/desc_walker.sv
module desc_walker
  import dw_pkg::*;
#(
  parameter int AW        = 32,
  parameter int POLL_WAIT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   base_addr,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_valid,
  input  logic [DW-1:0]   rd_data,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            buf_valid,
  output logic [AW-1:0]   buf_addr,
  output logic [SZ_W-1:0] buf_len,
  input  logic            buf_done,
  output logic            stalled
);
  localparam int IDXW = $clog2(DESC_WORDS);
  localparam int PW   = $clog2(POLL_WAIT + 1);
  localparam logic [DW-1:0] OWN_MASK = DW'(1) << OWN_BIT;

  walk_st_e                     st;
  logic [AW-1:0]                cur_addr, base_q, nxt_addr;
  logic [IDXW-1:0]              word_idx;
  logic [PW-1:0]                poll_cnt;
  logic                         on_second;
  logic [DESC_WORDS-1:0][DW-1:0] words;
  logic [SZ_W-1:0]              len1, len2;
  logic                         use1, use2, eor, chain;
  logic                         cap;

  assign cap = (st == ST_WAIT) && rd_valid;

  dw_desc_regs #(.NW(DESC_WORDS), .W(DW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .load  (cap),
    .idx   (word_idx),
    .din   (rd_data),
    .words (words)
  );

  dw_buf_select #(.SZW(SZ_W)) u_sel (
    .ctrl_word (words[1]),
    .len1      (len1),
    .len2      (len2),
    .use1      (use1),
    .use2      (use2),
    .eor       (eor),
    .chain     (chain)
  );

  dw_next_addr #(.AW(AW)) u_next (
    .cur   (cur_addr),
    .base  (base_q),
    .link  (words[3]),
    .eor   (eor),
    .chain (chain),
    .nxt   (nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      buf_valid <= 1'b0;
      buf_addr  <= '0;
      buf_len   <= '0;
      stalled   <= 1'b0;
      cur_addr  <= '0;
      base_q    <= '0;
      word_idx  <= '0;
      poll_cnt  <= '0;
      on_second <= 1'b0;
    end else begin
      rd_en <= 1'b0;
      wr_en <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            base_q   <= base_addr;
            cur_addr <= base_addr;
            word_idx <= '0;
            st       <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          rd_en   <= 1'b1;
          rd_addr <= cur_addr + (AW'(word_idx) << 2);
          st      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_valid) begin
            if (word_idx == '0 && !rd_data[OWN_BIT]) begin
              stalled  <= 1'b1;
              poll_cnt <= '0;
              st       <= ST_STALL;
            end else begin
              if (word_idx == '0)
                stalled <= 1'b0;
              if (word_idx == IDXW'(DESC_WORDS - 1)) begin
                st <= ST_PICK;
              end else begin
                word_idx <= word_idx + 1'b1;
                st       <= ST_ISSUE;
              end
            end
          end
        end
        ST_STALL: begin
          poll_cnt <= poll_cnt + 1'b1;
          if (poll_cnt == PW'(POLL_WAIT - 1))
            st <= ST_ISSUE;
        end
        ST_PICK: begin
          if (use1) begin
            buf_valid <= 1'b1;
            buf_addr  <= words[2][AW-1:0];
            buf_len   <= len1;
            on_second <= 1'b0;
            st        <= ST_BUF;
          end else if (use2) begin
            buf_valid <= 1'b1;
            buf_addr  <= words[3][AW-1:0];
            buf_len   <= len2;
            on_second <= 1'b1;
            st        <= ST_BUF;
          end else begin
            st <= ST_CLEAR;
          end
        end
        ST_BUF: begin
          if (buf_done) begin
            if (!on_second && use2) begin
              buf_addr  <= words[3][AW-1:0];
              buf_len   <= len2;
              on_second <= 1'b1;
            end else begin
              buf_valid <= 1'b0;
              st        <= ST_CLEAR;
            end
          end
        end
        ST_CLEAR: begin
          wr_en    <= 1'b1;
          wr_addr  <= cur_addr;
          wr_data  <= words[0] & ~OWN_MASK;
          cur_addr <= nxt_addr;
          word_idx <= '0;
          st       <= ST_ISSUE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dw_walker_chk.sv
module dw_walker_chk #(
  parameter int AW  = 32,
  parameter int SZW = 11
) (
  input logic           clk,
  input logic           rst,
  input logic           rd_en,
  input logic [AW-1:0]  rd_addr,
  input logic           wr_en,
  input logic [31:0]    wr_data,
  input logic           buf_valid,
  input logic [AW-1:0]  buf_addr,
  input logic [SZW-1:0] buf_len,
  input logic           buf_done,
  input logic           stalled
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rd_en && !wr_en && !buf_valid && !stalled));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr[1:0] == 2'b00));

  assert_no_buf_when_stalled_R3: assert property (@(posedge clk) disable iff (rst)
    stalled |-> !buf_valid);

  assert_len_rounded_R4: assert property (@(posedge clk) disable iff (rst)
    buf_valid |-> (buf_len[1:0] == 2'b00 && buf_len != '0));

  assert_hold_until_done_R10: assert property (@(posedge clk) disable iff (rst)
    (buf_valid && !buf_done) |=> (buf_valid && $stable(buf_addr) && $stable(buf_len)));

  assert_own_cleared_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !wr_data[31]);

  assert_one_port_R11: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));
endmodule

bind desc_walker dw_walker_chk #(.AW(AW), .SZW(dw_pkg::SZ_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .buf_valid (buf_valid),
  .buf_addr  (buf_addr),
  .buf_len   (buf_len),
  .buf_done  (buf_done),
  .stalled   (stalled)
);

// File: tb/desc_walker_tb.sv
`timescale 1ns/1ps
module desc_walker_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          rd_en, wr_en, buf_valid, stalled;
  logic [AW-1:0] rd_addr, wr_addr, buf_addr;
  logic          rd_valid = 1'b0;
  logic [31:0]   rd_data = '0;
  logic [31:0]   wr_data;
  logic [10:0]   buf_len;
  logic          buf_done = 1'b0;

  always #2 clk = ~clk;

  desc_walker #(.AW(AW), .POLL_WAIT(8)) u_dut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_len(buf_len),
    .buf_done(buf_done), .stalled(stalled)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] mem [0:1023];
  logic [31:0] exp_ba [$];
  int          exp_bl [$];
  string       exp_br [$];
  logic [31:0] exp_wa [$];
  logic [31:0] exp_wd [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // memory model: one-cycle read latency, status write-back
  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rd_en) begin
      rd_valid <= 1'b1;
      rd_data  <= mem[rd_addr[11:2]];
    end
    if (wr_en) mem[wr_addr[11:2]] <= wr_data;
  end

  // driver: lays a descriptor in memory and pushes what the rules predict
  task automatic put_desc(input logic [31:0] a, input bit own, input bit eor,
                          input bit chain, input int s1, input int s2,
                          input logic [31:0] a1, input logic [31:0] a2,
                          input logic [7:0] tag, input string req);
    logic [31:0] w0, w1;
    int l1, l2;
    bit u2;
    w0 = {own, 23'd0, tag};
    w1 = (32'(eor) << 25) | (32'(chain) << 24) | (32'(s2 & 11'h7ff) << 11) | 32'(s1 & 11'h7ff);
    mem[a[11:2]]     = w0;
    mem[a[11:2] + 1] = w1;
    mem[a[11:2] + 2] = a1;
    mem[a[11:2] + 3] = a2;
    l1 = s1 & ~3;
    l2 = s2 & ~3;
    u2 = (l2 != 0) && (!chain || eor);
    if (l1 != 0) begin exp_ba.push_back(a1); exp_bl.push_back(l1); exp_br.push_back(req); end
    if (u2)      begin exp_ba.push_back(a2); exp_bl.push_back(l2); exp_br.push_back(req); end
    exp_wa.push_back(a);
    exp_wd.push_back({1'b0, 23'd0, tag});
  endtask

  // monitor + data mover: compare each presented buffer, then complete it
  initial begin
    forever begin
      @(negedge clk);
      if (buf_valid) begin
        logic [31:0] ga;
        logic [10:0] gl;
        ga = buf_addr;
        gl = buf_len;
        if (exp_ba.size() == 0) begin
          chk(0, "R10", "unexpected buffer", ga, 0);
        end else begin
          logic [31:0] ea;
          int el;
          string er;
          ea = exp_ba.pop_front();
          el = exp_bl.pop_front();
          er = exp_br.pop_front();
          chk(ga == ea, er, "buffer address", ga, ea);
          chk(int'(gl) == el, "R4", "buffer length", 32'(gl), 32'(el));
        end
        repeat (2) @(negedge clk);
        chk(buf_valid && buf_addr == ga && buf_len == gl, "R10", "buffer held",
            buf_addr, ga);
        buf_done = 1'b1;
        @(negedge clk);
        buf_done = 1'b0;
      end
    end
  end

  // monitor: ownership write-backs
  initial begin
    forever begin
      @(negedge clk);
      if (wr_en) begin
        if (exp_wa.size() == 0) begin
          chk(0, "R11", "unexpected write", wr_addr, 0);
        end else begin
          logic [31:0] ea, ed;
          ea = exp_wa.pop_front();
          ed = exp_wd.pop_front();
          chk(wr_addr == ea, "R7", "write-back address (walk order)", wr_addr, ea);
          chk(wr_data == ed, "R11", "write-back data", wr_data, ed);
        end
      end
    end
  end

  // monitor: first descriptor fetch order
  initial begin
    int n = 0;
    while (n < 4) begin
      @(negedge clk);
      if (rd_en) begin
        chk(rd_addr == 32'(n * 4), "R2", "fetch address", rd_addr, 32'(n * 4));
        n++;
      end
    end
  end

  task automatic wait_quiet(input string req);
    int t = 0;
    while (!(exp_ba.size() == 0 && exp_wa.size() == 0 && stalled) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, req, "walk reached stall with all items seen", 32'(t), 3000);
  endtask

  task automatic count_polls(input logic [31:0] a, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rd_en && rd_addr == a) n++;
    end
  endtask

  initial begin
    int polls;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    chk(!rd_en && !wr_en && !buf_valid && !stalled, "R1", "idle during reset",
        {rd_en, wr_en, buf_valid, stalled}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_en && !wr_en && !buf_valid && !stalled, "R1", "idle after reset",
        {rd_en, wr_en, buf_valid, stalled}, 0);

    put_desc(32'h000, 1, 0, 0, 64, 32, 32'h1000, 32'h2000, 8'h10, "R7");
    put_desc(32'h010, 1, 0, 0,  0,  8, 32'h1100, 32'h2100, 8'h11, "R5");
    put_desc(32'h020, 1, 0, 1, 20, 40, 32'h3000, 32'h0080, 8'h12, "R8");
    put_desc(32'h080, 1, 0, 0,  6,  3, 32'h3100, 32'h3180, 8'h13, "R4");
    put_desc(32'h090, 1, 0, 0,  0,  0, 32'h3400, 32'h3480, 8'h14, "R6");
    put_desc(32'h0A0, 1, 1, 1, 12, 16, 32'h3200, 32'h0300, 8'h15, "R9");

    base_addr = 32'h0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    // after the wrap the base descriptor was handed back to the host
    wait_quiet("R9");
    chk(stalled == 1'b1, "R3", "stalled on host-owned base", 32'(stalled), 1);
    count_polls(32'h000, 60, polls);
    chk(polls >= 3, "R3", "re-polls of base status", 32'(polls), 3);
    chk(!buf_valid, "R3", "no buffer while stalled", 32'(buf_valid), 0);

    // re-arm the base descriptor in place
    put_desc(32'h000, 1, 0, 0, 100, 0, 32'h4000, 32'h4400, 8'h20, "R3");
    wait_quiet("R3");
    count_polls(32'h010, 60, polls);
    chk(polls >= 1, "R6", "next stall at base+16", 32'(polls), 1);
    chk(exp_ba.size() == 0 && exp_wa.size() == 0, "R10", "all predicted items seen",
        32'(exp_ba.size() + exp_wa.size()), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule